// File: doc/BRIEF.md
# Hotplug Slot Event Interrupt Unit

This unit sits inside a multi-slot hotplug controller and turns sampled slot signals into latched events and one interrupt line. For every slot it keeps a status word. The word shows the live slot inputs, five sticky event flags and a set of mask bits. A controller-wide word holds four enable masks and two sticky latches: one for command completion and one for arbiter events. A read-only locator word tells software which sources are pending: command completion or a particular slot.

Software reaches everything through a 32-bit register port. Reads are combinational, from the address presented. Writes take effect at the clock edge where `wr_en` is high. Event flags clear when a one is written to them. The command engine reports finished commands with a one-cycle `cmd_done` pulse. The interrupt output is combinational from registered state.

Top module: `hp_evt_unit`

## Requirements
- R1: A slot event flag sets at the clock edge after its input changes. Presence code (any change) is bit 16, isolated power fault rising is bit 17, button press rising is bit 18, latch sensor (any change) is bit 19, and connected power fault rising is bit 20. Falling faults and button release set nothing. A set flag stays set until it is cleared.
- R2: Writing a word to a slot with a 1 in an event bit position clears that flag. A 0 in that position leaves the flag unchanged.
- R3: If an event arrives in the same cycle as a clear of the same flag, the flag stays set.
- R4: Slot bits 28:24 mask events 16..20 in the same order. A slot reports pending only when some flag is set and its mask bit is 0.
- R5: Slot bit 15 and bits 23:21 read 0, and writes to them change nothing. In the controller word, bits 31:18 read 0.
- R6: Address 0 is the controller word, address 1 is the locator, and address 2+i is slot i. In the locator, bit 0 equals the command-completion latch and bit i+1 is set while slot i is pending. All other locator bits read 0.
- R7: In the controller word, bit 0 is the global interrupt mask, bit 1 the global system-error mask, bit 2 the command-interrupt mask and bit 3 the arbiter system-error mask. Bit 16 latches `cmd_done`, bit 17 latches `arb_event`, and both clear on a written 1.
- R8: `irq` is 1 only when the global interrupt mask is 0 and either some slot is pending, or the command latch is set while the command-interrupt mask is 0.
- R9: Each slot word shows live inputs. Bit 6 reads 0 while either power fault is present. Bit 7 is the button, bit 8 the latch sensor, bit 9 the 66 MHz capability, and bits 11:10 the presence code, where 3 means empty.
- R10: After reset, all mask bits read 1, all event flags and latches read 0, and `irq` is 0.
- R11: Slot bits 29 (latch-change system-error mask) and 30 (connected-fault system-error mask) are stored and read back, and they have no effect on `irq` or the locator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Register address (0 controller, 1 locator, 2+i slot i) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| slot_present | input | 2*NUM_SLOTS | Presence code per slot, 3 = empty |
| slot_iso_fault | input | NUM_SLOTS | Isolated power fault, high = fault |
| slot_conn_fault | input | NUM_SLOTS | Connected power fault, high = fault |
| slot_button | input | NUM_SLOTS | Attention button, high = pressed |
| slot_latch | input | NUM_SLOTS | Latch sensor, high = open |
| slot_m66 | input | NUM_SLOTS | 66 MHz capability of the card |
| cmd_done | input | 1 | One-cycle command completion pulse |
| arb_event | input | 1 | One-cycle arbiter event pulse |
| irq | output | 1 | Interrupt request |

## Verification
A table drives each of the five event kinds on one slot, under several mask patterns. For each case it checks both the sticky flag and the locator/`irq` result. This separates a wrong edge detector from a wrong mask bit position. Directed cases then cover the rest:
- a clear that collides with a new event;
- clears written with 0 versus 1;
- events on a higher slot, to catch locator bit misplacement;
- the global and command masks, which gate `irq` separately from the locator;
- the system-error masks, which must not gate anything.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;

    localparam int EVT_N    = 5;   // latched events per slot
    localparam int SMASK_W  = 7;   // five interrupt masks + two system-error masks
    localparam int EVT_LSB  = 16;
    localparam int MASK_LSB = 24;

    // event index inside the 5-bit event field
    typedef enum logic [2:0] {
        EV_PRES  = 3'd0,
        EV_ISOF  = 3'd1,
        EV_BTN   = 3'd2,
        EV_LATCH = 3'd3,
        EV_CONF  = 3'd4
    } evt_idx_e;

    typedef struct packed {
        logic [1:0] pres;
        logic       iso_flt;
        logic       con_flt;
        logic       btn;
        logic       latch;
        logic       m66;
    } slot_in_t;

    typedef struct packed {
        logic arb_serr_m;   // bit 3
        logic cmd_int_m;    // bit 2
        logic g_serr_m;     // bit 1
        logic g_int_m;      // bit 0
    } ctrl_mask_t;

    function automatic logic [EVT_N-1:0] detect_events(slot_in_t now, slot_in_t prev);
        logic [EVT_N-1:0] e;
        e           = '0;
        e[EV_PRES]  = (now.pres != prev.pres);
        e[EV_ISOF]  = now.iso_flt & ~prev.iso_flt;
        e[EV_BTN]   = now.btn & ~prev.btn;
        e[EV_LATCH] = now.latch ^ prev.latch;
        e[EV_CONF]  = now.con_flt & ~prev.con_flt;
        return e;
    endfunction

    function automatic logic [31:0] slot_word(slot_in_t live, logic [EVT_N-1:0] evt,
                                              logic [SMASK_W-1:0] msk);
        logic [31:0] w;
        w                              = '0;
        w[6]                           = ~(live.iso_flt | live.con_flt);
        w[7]                           = live.btn;
        w[8]                           = live.latch;
        w[9]                           = live.m66;
        w[11:10]                       = live.pres;
        w[EVT_LSB +: EVT_N]            = evt;
        w[MASK_LSB +: SMASK_W]         = msk;
        return w;
    endfunction

endpackage

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  slot_in_t           sin,
    input  logic               wr_hit,
    input  logic [SMASK_W-1:0] wr_mask,
    input  logic [EVT_N-1:0]   wr_clr,
    output logic [31:0]        rd_word,
    output logic               pend,
    output logic [EVT_N-1:0]   evt_o
);
    slot_in_t           prev_q;
    logic [EVT_N-1:0]   evt_q;
    logic [SMASK_W-1:0] mask_q;
    logic [EVT_N-1:0]   seen;
    logic [EVT_N-1:0]   clr;

    assign seen = detect_events(sin, prev_q);
    assign clr  = wr_hit ? wr_clr : '0;

    always_ff @(posedge clk) begin
        prev_q <= sin;               // tracks inputs even in reset: no false edge
        if (rst) begin
            evt_q  <= '0;
            mask_q <= '1;
        end else begin
            evt_q <= (evt_q & ~clr) | seen;   // a new event beats the clear
            if (wr_hit)
                mask_q <= wr_mask;
        end
    end

    assign pend    = |(evt_q & ~mask_q[EVT_N-1:0]);
    assign rd_word = slot_word(sin, evt_q, mask_q);
    assign evt_o   = evt_q;
endmodule

// File: rtl/hp_ctrl_regs.sv
module hp_ctrl_regs
    import hp_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_done,
    input  logic        arb_event,
    input  logic        wr_hit,
    input  ctrl_mask_t  wr_mask,
    input  logic [1:0]  wr_clr,
    output ctrl_mask_t  mask_o,
    output logic        cmd_lat,
    output logic        arb_lat,
    output logic [31:0] rd_word
);
    ctrl_mask_t mask_q;
    logic       cmd_q;
    logic       arb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            cmd_q  <= 1'b0;
            arb_q  <= 1'b0;
        end else begin
            cmd_q <= (cmd_q & ~(wr_hit & wr_clr[0])) | cmd_done;
            arb_q <= (arb_q & ~(wr_hit & wr_clr[1])) | arb_event;
            if (wr_hit)
                mask_q <= wr_mask;
        end
    end

    always_comb begin
        rd_word       = '0;
        rd_word[3:0]  = mask_q;
        rd_word[16]   = cmd_q;
        rd_word[17]   = arb_q;
    end

    assign mask_o  = mask_q;
    assign cmd_lat = cmd_q;
    assign arb_lat = arb_q;
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
    import hp_evt_pkg::*;
#(
    parameter int NUM_SLOTS = 4     // at most 31: one locator bit per slot above bit 0
) (
    input  logic [NUM_SLOTS-1:0] slot_pend,
    input  logic                 cmd_lat,
    input  ctrl_mask_t           masks,
    output logic [31:0]          loc_word,
    output logic                 irq
);
    always_comb begin
        loc_word                = '0;
        loc_word[0]             = cmd_lat;
        loc_word[NUM_SLOTS:1]   = slot_pend;
    end

    assign irq = ~masks.g_int_m & ((cmd_lat & ~masks.cmd_int_m) | (|slot_pend));
endmodule

// File: rtl/hp_evt_unit.sv
module hp_evt_unit
    import hp_evt_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    localparam int ADDR_W    = $clog2(NUM_SLOTS + 2)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wr_data,
    output logic [31:0]            rd_data,
    input  logic [2*NUM_SLOTS-1:0] slot_present,
    input  logic [NUM_SLOTS-1:0]   slot_iso_fault,
    input  logic [NUM_SLOTS-1:0]   slot_conn_fault,
    input  logic [NUM_SLOTS-1:0]   slot_button,
    input  logic [NUM_SLOTS-1:0]   slot_latch,
    input  logic [NUM_SLOTS-1:0]   slot_m66,
    input  logic                   cmd_done,
    input  logic                   arb_event,
    output logic                   irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_LOC  = ADDR_W'(1);

    logic [31:0]              slot_rd [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]     slot_pend;
    logic [EVT_N*NUM_SLOTS-1:0] evt_flat;
    logic [31:0]              ctrl_rd;
    logic [31:0]              loc_word;
    ctrl_mask_t               ctrl_mask;
    logic                     cmd_lat;
    logic                     arb_lat;
    logic                     ctrl_hit;

    // data bits with no storage behind them
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31], wr_data[23:21], wr_data[15:4], arb_lat};

    assign ctrl_hit = wr_en && (addr == A_CTRL);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
            slot_in_t sin;
            logic     hit;
            assign sin.pres    = slot_present[2*gi +: 2];
            assign sin.iso_flt = slot_iso_fault[gi];
            assign sin.con_flt = slot_conn_fault[gi];
            assign sin.btn     = slot_button[gi];
            assign sin.latch   = slot_latch[gi];
            assign sin.m66     = slot_m66[gi];
            assign hit         = wr_en && (addr == ADDR_W'(gi + 2));

            hp_slot_regs u_slot (
                .clk     (clk),
                .rst     (rst),
                .sin     (sin),
                .wr_hit  (hit),
                .wr_mask (wr_data[MASK_LSB +: SMASK_W]),
                .wr_clr  (wr_data[EVT_LSB +: EVT_N]),
                .rd_word (slot_rd[gi]),
                .pend    (slot_pend[gi]),
                .evt_o   (evt_flat[EVT_N*gi +: EVT_N])
            );
        end
    endgenerate

    hp_ctrl_regs u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_done  (cmd_done),
        .arb_event (arb_event),
        .wr_hit    (ctrl_hit),
        .wr_mask   (ctrl_mask_t'(wr_data[3:0])),
        .wr_clr    (wr_data[17:16]),
        .mask_o    (ctrl_mask),
        .cmd_lat   (cmd_lat),
        .arb_lat   (arb_lat),
        .rd_word   (ctrl_rd)
    );

    hp_irq_locator #(.NUM_SLOTS(NUM_SLOTS)) u_loc (
        .slot_pend (slot_pend),
        .cmd_lat   (cmd_lat),
        .masks     (ctrl_mask),
        .loc_word  (loc_word),
        .irq       (irq)
    );

    always_comb begin
        rd_data = '0;
        if (addr == A_CTRL)
            rd_data = ctrl_rd;
        else if (addr == A_LOC)
            rd_data = loc_word;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (addr == ADDR_W'(i + 2))
                rd_data = slot_rd[i];
    end
endmodule

// File: rtl/hp_evt_unit_chk.sv
module hp_evt_unit_chk
    import hp_evt_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    localparam int ADDR_W    = $clog2(NUM_SLOTS + 2)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          addr,
    input logic [31:0]                rd_data,
    input logic                       irq,
    input logic [31:0]                loc_word,
    input ctrl_mask_t                 ctrl_mask,
    input logic                       cmd_done,
    input logic                       cmd_lat,
    input logic [EVT_N*NUM_SLOTS-1:0] evt_flat
);
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((evt_flat & $past(evt_flat)) == $past(evt_flat)));   // R1

    AST_RSVD_SLOT: assert property (@(posedge clk) disable iff (rst)
        (addr >= ADDR_W'(2) && addr < ADDR_W'(NUM_SLOTS + 2))
            |-> (rd_data[15] == 1'b0 && rd_data[23:21] == 3'b000));       // R5

    AST_RSVD_CTRL: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(0)) |-> (rd_data[31:18] == 14'd0));              // R5

    AST_CMD_LATCH: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> cmd_lat);                                            // R7

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
        ctrl_mask.g_int_m |-> !irq);                                      // R8

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (loc_word != 32'd0));                                     // R8

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (ctrl_mask == 4'hF && evt_flat == '0 && !cmd_lat));       // R10
endmodule

bind hp_evt_unit hp_evt_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .rd_data   (rd_data),
    .irq       (irq),
    .loc_word  (loc_word),
    .ctrl_mask (ctrl_mask),
    .cmd_done  (cmd_done),
    .cmd_lat   (cmd_lat),
    .evt_flat  (evt_flat)
);

// File: tb/tb_hp_evt_unit.sv
`timescale 1ns/1ps
module tb_hp_evt_unit;
    localparam int N      = 4;
    localparam int ADDR_W = $clog2(N + 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic [2*N-1:0]    pres = '1;
    logic [N-1:0]      isof = '0, conf = '0, btn = '0, lat = '0, m66 = '0;
    logic              cmd_done = 1'b0, arb_event = 1'b0;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hp_evt_unit #(.NUM_SLOTS(N)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .slot_present(pres), .slot_iso_fault(isof),
        .slot_conn_fault(conf), .slot_button(btn), .slot_latch(lat),
        .slot_m66(m66), .cmd_done(cmd_done), .arb_event(arb_event), .irq(irq)
    );

    // {event index[2:0], mask[4:0]}; pending expected when mask[event] is 0
    localparam logic [7:0] VEC [8] = '{
        {3'd0, 5'b00000}, {3'd1, 5'b00000}, {3'd2, 5'b00000}, {3'd3, 5'b00000},
        {3'd4, 5'b00000}, {3'd0, 5'b00001}, {3'd2, 5'b00100}, {3'd3, 5'b10111}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        addr = ADDR_W'(a);
        #1 v = rd_data;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic slot_wr(input int s, input logic [6:0] m, input logic [4:0] c);
        wr(s + 2, {1'b0, m, 3'b000, c, 16'h0000});
    endtask

    task automatic fire(input int s, input int e);
        @(negedge clk);
        case (e)
            0: pres[2*s +: 2] = (pres[2*s +: 2] == 2'd3) ? 2'd1 : 2'd3;
            1: isof[s] = 1'b1;
            2: btn[s] = 1'b1;
            3: lat[s] = ~lat[s];
            default: conf[s] = 1'b1;
        endcase
        @(negedge clk);
        isof[s] = 1'b0; btn[s] = 1'b0; conf[s] = 1'b0;   // releases latch nothing
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got hang expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rd(0, v); check("R10 ctrl", v, 32'h0000000F);
        rd(1, v); check("R10 loc", v, 32'h0);
        rd(2, v); check("R10 R9 slot0", v, 32'h7F000C40);
        check("R10 irq", {31'd0, irq}, 32'd0);

        wr(0, 32'h0);   // open all controller masks

        // table: R1 R4 R6 R8
        for (int k = 0; k < 8; k++) begin
            int   e;
            logic [4:0] m;
            logic exp;
            e   = int'(VEC[k][7:5]);
            m   = VEC[k][4:0];
            exp = ~m[e];
            slot_wr(0, {2'b11, m}, 5'h1F);
            fire(0, e);
            rd(2, v); check("R1 event flag", {31'd0, v[16+e]}, 32'd1);
            check("R4 mask bits", {25'd0, v[30:24]}, {25'd0, 2'b11, m});
            rd(1, v); check("R6 locator", v, {30'd0, exp, 1'b0});
            check("R8 irq", {31'd0, irq}, {31'd0, exp});
            slot_wr(0, 7'h7F, 5'h1F);
        end

        // R2 write-one-to-clear, zero leaves flag
        fire(0, 3);
        slot_wr(0, 7'h7F, 5'h00);
        rd(2, v); check("R2 zero keeps", {31'd0, v[19]}, 32'd1);
        slot_wr(0, 7'h7F, 5'b01000);
        rd(2, v); check("R2 one clears", {31'd0, v[19]}, 32'd0);

        // R3 collision: clear and presence change in one cycle
        fire(0, 0);
        @(negedge clk);
        addr = ADDR_W'(2); wr_data = {8'h7F, 3'b000, 5'h01, 16'h0}; wr_en = 1'b1;
        pres[1:0] = (pres[1:0] == 2'd3) ? 2'd1 : 2'd3;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2, v); check("R3 event wins", {31'd0, v[16]}, 32'd1);
        slot_wr(0, 7'h7F, 5'h1F);

        // R5 reserved bits
        wr(2, 32'h7FE08000);
        rd(2, v); check("R5 slot rsvd", v & 32'h00E08000, 32'h0);
        wr(0, 32'hFFFC0000);
        rd(0, v); check("R5 ctrl rsvd", v, 32'h0);

        // R6 higher slot position
        slot_wr(2, 7'h60, 5'h1F);
        fire(2, 2);
        rd(1, v); check("R6 slot2 bit3", v, 32'h00000008);
        check("R8 slot2 irq", {31'd0, irq}, 32'd1);

        // R8 global mask gates irq
        wr(0, 32'h00000001);
        #1 check("R8 global mask", {31'd0, irq}, 32'd0);
        rd(1, v); check("R8 loc unaffected", v, 32'h00000008);
        slot_wr(2, 7'h7F, 5'h1F);

        // R7 command latch and command mask
        wr(0, 32'h00000004);
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
        rd(0, v); check("R7 cmd latch", v, 32'h00010004);
        rd(1, v); check("R6 cmd loc", v, 32'h00000001);
        check("R7 cmd masked irq", {31'd0, irq}, 32'd0);
        wr(0, 32'h00000000);
        #1 check("R7 cmd irq", {31'd0, irq}, 32'd1);
        wr(0, 32'h00010000);
        rd(0, v); check("R7 cmd clear", v, 32'h0);
        @(negedge clk); arb_event = 1'b1;
        @(negedge clk); arb_event = 1'b0;
        rd(0, v); check("R7 arb latch", v, 32'h00020000);
        check("R7 arb no irq", {31'd0, irq}, 32'd0);
        wr(0, 32'h00020000);
        rd(0, v); check("R7 arb clear", v, 32'h0);

        // R9 live status
        @(negedge clk);
        conf[1] = 1'b1; btn[1] = 1'b1; lat[1] = 1'b1; m66[1] = 1'b1; pres[3:2] = 2'd2;
        rd(3, v); check("R9 live", v & 32'h00000FC0, 32'h00000B80);
        @(negedge clk);
        conf[1] = 1'b0; btn[1] = 1'b0;
        slot_wr(1, 7'h1F, 5'h1F);

        // R11 system-error masks stored, no effect
        fire(1, 3);
        slot_wr(1, 7'h1F, 5'h00);
        rd(3, v); check("R11 serr masks", {25'd0, v[30:24]}, 32'h1F);
        check("R11 no irq", {31'd0, irq}, 32'd0);
        rd(1, v); check("R11 no loc", v, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule